// File: doc/BRIEF.md
# Watchdog Timer with Reset Generation

An eight-bit up-counter, advanced by a power-of-two prescaler, guards a running system. Software must reload the counter, usually with zero, before it wraps from its maximum value back to zero. If the wrap happens in watchdog mode, the block does three things. It drives a fixed-width overflow pulse to the outside. It sets a sticky overflow flag. If software has allowed it, it also raises an internal system reset of fixed length, tagged as either a power-on or a manual reset.

In interval mode the same wrap does something else. It sets an interval flag and raises an interrupt request, and produces no pulse and no reset. An external reset-pin event has priority over everything. It clears the counter, both flags and any running pulse, so an overflow in the same cycle is lost. The control register keeps its contents.

Software has one write port with three targets, selected by `wr_sel_i`: 0 is the counter, 1 is control and 2 is status. A write to any target takes effect at the next clock edge.

Top module: `wdog_rstgen`

## Requirements
- R1: Control write (select 1) fields: clock select at bits 2:0, timer enable at bit 3, mode at bit 4 (1 = watchdog, 0 = interval), reset enable at bit 5, and reset type at bit 6 (1 = power-on, 0 = manual). While the timer enable is 0, the counter is held at zero, counter writes are ignored and no overflow occurs.
- R2: A counter write (select 0) with the timer enabled loads the written byte at the next edge. It takes precedence over a prescaler tick in the same cycle.
- R3: The counter advances once every 2^cs clock cycles, where cs is the clock-select field (divide by 1 up to 128).
- R4: A wrap from 0xFF to 0x00 in watchdog mode raises `ovf_pulse_o` and `ovf_flag_o` at the same edge that shows the counter at zero.
- R5: The overflow pulse lasts 132 cycles when reset enable is 1 and 130 cycles when it is 0.
- R6: With reset enable at 1, `sys_rst_o` rises in the same cycle as `ovf_pulse_o` and lasts 518 cycles. With reset enable at 0, it stays low.
- R7: `sys_rst_por_o` holds the reset-type bit captured at the overflow (1 = power-on, 0 = manual).
- R8: Status write (select 2): writing 0 to bit 0 clears the overflow flag and writing 0 to bit 1 clears the interval flag. Writing 1 to either bit has no effect.
- R9: A wrap that occurs while either pulse timer is active does not restart or extend the pulses.
- R10: An `ext_rst_i` cycle clears the counter, both flags, and both pulse outputs at the next edge. This holds even when a wrap happens in the same cycle.
- R11: In interval mode a wrap sets `ivl_flag_o` and `irq_o` and produces no pulse and no reset.
- R12: After `rst`, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_i | input | 1 | External reset-pin event, one cycle or longer |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 counter, 1 control, 2 status |
| wr_data_i | input | 8 | Write data |
| cnt_o | output | 8 | Current counter value |
| ovf_pulse_o | output | 1 | External overflow pulse |
| sys_rst_o | output | 1 | Internal system reset |
| sys_rst_por_o | output | 1 | Reset type: 1 power-on, 0 manual |
| ovf_flag_o | output | 1 | Watchdog overflow flag |
| ivl_flag_o | output | 1 | Interval overflow flag |
| irq_o | output | 1 | Interval interrupt request |

## Verification
The assertions assume that `rst` is held for at least one edge before checking starts. They also assume that `ext_rst_i` and the write strobe are clean synchronous levels that do not change between edges. The bench meets both by driving every input only on falling clock edges. It keeps the counter away from unintended wraps by disabling the timer after each overflow scenario. It aligns the external reset to the exact wrap edge by counting edges from a counter load of 0xFD at divide-by-one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 8;
  localparam int CS_W  = 3;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  typedef struct packed {
    logic            por;
    logic            rsten;
    logic            wdmode;
    logic            en;
    logic [CS_W-1:0] cs;
  } ctrl_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int CS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic [CS_W-1:0] cs_i,
  output logic            tick_o
);
  localparam int PRE_W = (1 << CS_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask   = ({{(PRE_W-1){1'b0}}, 1'b1} << cs_i) - 1'b1;
  assign tick_o = en_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !en_i) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  assign wrap_o = en_i && !clr_i && !ld_i && tick_i && (cnt_o == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst || clr_i || !en_i) cnt_o <= '0;
    else if (ld_i)             cnt_o <= ld_val_i;
    else if (tick_i)           cnt_o <= cnt_o + 1'b1;
  end

  AST_DIS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> cnt_o == '0); // R1
  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ld_i && en_i && !clr_i) |=> cnt_o == $past(ld_val_i)); // R2
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic [W-1:0] len_i,
  output logic         act_o
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      act_o  <= 1'b0;
      left_q <= '0;
    end else if (start_i && !act_o) begin
      act_o  <= 1'b1;
      left_q <= len_i - 1'b1;
    end else if (act_o) begin
      if (left_q == '0) act_o  <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (act_o && left_q != '0 && !clr_i) |=> act_o); // R5
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (rst)
    (act_o && left_q != '0 && !clr_i) |=> left_q == $past(left_q) - 1'b1); // R9
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen
  import wdog_pkg::*;
#(
  parameter int OVF_LONG  = 132,
  parameter int OVF_SHORT = 130,
  parameter int RST_LEN   = 518
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_rst_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [7:0]       wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_pulse_o,
  output logic             sys_rst_o,
  output logic             sys_rst_por_o,
  output logic             ovf_flag_o,
  output logic             ivl_flag_o,
  output logic             irq_o
);
  localparam int PW = $clog2(RST_LEN + 1);

  ctrl_t      ctrl_q;
  logic       tick, wrap, busy, wd_ovf;
  logic       wr_cnt, wr_ctrl, wr_stat;
  logic [PW-1:0] ovf_len;
  logic       unused_bit;

  assign unused_bit = wr_data_i[7];
  assign wr_cnt  = wr_en_i && (wr_sel_i == SEL_CNT);
  assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign wr_stat = wr_en_i && (wr_sel_i == SEL_STAT);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data_i[6:0]);
  end

  wdog_prescale #(.CS_W(CS_W)) u_pre (
    .clk(clk), .rst(rst), .en_i(ctrl_q.en), .cs_i(ctrl_q.cs), .tick_o(tick)
  );

  wdog_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(ext_rst_i), .en_i(ctrl_q.en), .tick_i(tick),
    .ld_i(wr_cnt), .ld_val_i(wr_data_i[CNT_W-1:0]), .cnt_o(cnt_o), .wrap_o(wrap)
  );

  assign busy    = ovf_pulse_o || sys_rst_o;
  assign wd_ovf  = wrap && ctrl_q.wdmode && !busy;
  assign ovf_len = ctrl_q.rsten ? PW'(OVF_LONG) : PW'(OVF_SHORT);

  wdog_pulse #(.W(PW)) u_ovf_pulse (
    .clk(clk), .rst(rst), .clr_i(ext_rst_i), .start_i(wd_ovf),
    .len_i(ovf_len), .act_o(ovf_pulse_o)
  );

  wdog_pulse #(.W(PW)) u_rst_pulse (
    .clk(clk), .rst(rst), .clr_i(ext_rst_i), .start_i(wd_ovf && ctrl_q.rsten),
    .len_i(PW'(RST_LEN)), .act_o(sys_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst || ext_rst_i)              sys_rst_por_o <= 1'b0;
    else if (wd_ovf && ctrl_q.rsten)   sys_rst_por_o <= ctrl_q.por;
  end

  always_ff @(posedge clk) begin
    if (rst || ext_rst_i) begin
      ovf_flag_o <= 1'b0;
      ivl_flag_o <= 1'b0;
    end else begin
      if (wrap && ctrl_q.wdmode)            ovf_flag_o <= 1'b1;
      else if (wr_stat && !wr_data_i[0])    ovf_flag_o <= 1'b0;
      if (wrap && !ctrl_q.wdmode)           ivl_flag_o <= 1'b1;
      else if (wr_stat && !wr_data_i[1])    ivl_flag_o <= 1'b0;
    end
  end

  assign irq_o = ivl_flag_o;

  AST_RST_ALIGN: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $rose(ovf_pulse_o)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag_o && !ext_rst_i && !(wr_stat && !wr_data_i[0])) |=> ovf_flag_o); // R8
  AST_EXT_WINS: assert property (@(posedge clk) disable iff (rst)
    ext_rst_i |=> (!ovf_flag_o && !ovf_pulse_o && !sys_rst_o && cnt_o == '0)); // R10
  AST_IVL_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(ivl_flag_o) |-> !$rose(ovf_pulse_o)); // R11
endmodule

// File: tb/wdog_rstgen_tb.sv
module wdog_rstgen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_rst_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd3;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] cnt_o;
  logic ovf_pulse_o, sys_rst_o, sys_rst_por_o, ovf_flag_o, ivl_flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int ovf_q[$];
  int rlen_q[$];
  int rpor_q[$];

  always #5 clk = ~clk;

  wdog_rstgen u_dut (
    .clk(clk), .rst(rst), .ext_rst_i(ext_rst_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .cnt_o(cnt_o),
    .ovf_pulse_o(ovf_pulse_o), .sys_rst_o(sys_rst_o), .sys_rst_por_o(sys_rst_por_o),
    .ovf_flag_o(ovf_flag_o), .ivl_flag_o(ivl_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_sel_i = 2'd3;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: measures pulses and pops the expected item pushed by the driver.
  int  olen = 0, rlen = 0, rpor_seen = 0;
  logic oprev = 1'b0, rprev = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ovf_pulse_o) olen++;
      if (!ovf_pulse_o && oprev) begin
        if (ovf_q.size() == 0) chk("R9 unexpected overflow pulse", olen, 0);
        else chk("R5 overflow pulse width", olen, ovf_q.pop_front());
        olen = 0;
      end
      if (sys_rst_o && !rprev) rpor_seen = sys_rst_por_o;
      if (sys_rst_o) rlen++;
      if (!sys_rst_o && rprev) begin
        if (rlen_q.size() == 0) chk("R6 unexpected internal reset", rlen, 0);
        else begin
          chk("R6 internal reset width", rlen, rlen_q.pop_front());
          chk("R7 reset type", rpor_seen, rpor_q.pop_front());
        end
        rlen = 0;
      end
      oprev = ovf_pulse_o;
      rprev = sys_rst_o;
    end
  end

  task automatic period(input logic [7:0] ctl, input int exp);
    int gap;
    logic [7:0] v;
    wr(2'd1, ctl);
    wr(2'd0, 8'h00);
    v = cnt_o;
    while (cnt_o == v) @(negedge clk);
    v = cnt_o; gap = 0;
    while (cnt_o == v) begin @(negedge clk); gap++; end
    chk("R3 prescaler period", gap, exp);
  endtask

  task automatic run_ovf(input logic [7:0] ctl, input int plen, input bit rsten, input int por);
    wr(2'd1, ctl);
    ovf_q.push_back(plen);
    if (rsten) begin rlen_q.push_back(518); rpor_q.push_back(por); end
    wr(2'd0, 8'hFD);
    cyc(2);
    chk("R4 no pulse before wrap", ovf_pulse_o, 0);
    cyc(1);
    chk("R4 pulse at wrap", ovf_pulse_o, 1);
    chk("R4 counter wrapped", cnt_o, 0);
    chk("R4 flag set", ovf_flag_o, 1);
    chk("R6 reset aligned", sys_rst_o, int'(rsten));
    wr(2'd0, 8'hFF);  // R9: forced wrap while pulses run
    cyc(2);
    wr(2'd1, 8'h00);
    cyc(600);
    chk("R5 pulse ended", ovf_pulse_o, 0);
    chk("R6 reset ended", sys_rst_o, 0);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R12 reset state
    chk("R12 cnt", cnt_o, 0);
    chk("R12 outputs", {ovf_pulse_o, sys_rst_o, sys_rst_por_o, ovf_flag_o, ivl_flag_o, irq_o}, 0);

    // R1 disabled: writes ignored, counter stays zero
    wr(2'd1, 8'h70);
    wr(2'd0, 8'hFE);
    cyc(300);
    chk("R1 disabled counter", cnt_o, 0);

    // R2 immediate load at slow prescale
    wr(2'd1, 8'h1F);
    wr(2'd0, 8'h5A);
    chk("R2 load", cnt_o, 8'h5A);

    // R3 divide ratios
    period(8'h18, 1);
    period(8'h1A, 4);
    period(8'h1B, 8);

    // R4 R5 R6 R7 R9 with power-on type
    run_ovf(8'h78, 132, 1'b1, 1);

    // R8 writing 1 keeps the flag
    wr(2'd2, 8'h03);
    chk("R8 write one ignored", ovf_flag_o, 1);

    // R10 external reset in the wrap cycle
    wr(2'd1, 8'h78);
    wr(2'd0, 8'hFD);
    cyc(2);
    ext_rst_i = 1'b1;
    @(negedge clk);
    ext_rst_i = 1'b0;
    chk("R10 no pulse", ovf_pulse_o, 0);
    chk("R10 no reset", sys_rst_o, 0);
    chk("R10 flag cleared", ovf_flag_o, 0);
    chk("R10 counter cleared", cnt_o, 0);
    wr(2'd1, 8'h00);
    cyc(10);

    // R7 manual reset type
    run_ovf(8'h38, 132, 1'b1, 0);
    // R5 R6 reset disabled: short pulse, no reset
    run_ovf(8'h18, 130, 1'b0, 0);

    // R8 write zero clears
    wr(2'd2, 8'h02);
    chk("R8 clear", ovf_flag_o, 0);

    // R4 regular refresh prevents overflow
    wr(2'd1, 8'h78);
    for (int k = 0; k < 6; k++) begin
      wr(2'd0, 8'h00);
      cyc(200);
    end
    wr(2'd1, 8'h00);
    chk("R4 refresh no flag", ovf_flag_o, 0);

    // R11 interval mode
    wr(2'd1, 8'h08);
    wr(2'd0, 8'hFD);
    cyc(3);
    chk("R11 ivl flag", ivl_flag_o, 1);
    chk("R11 irq", irq_o, 1);
    chk("R11 no pulse", ovf_pulse_o, 0);
    chk("R11 no reset", sys_rst_o, 0);
    chk("R11 ovf flag untouched", ovf_flag_o, 0);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
    chk("R8 ivl clear", ivl_flag_o, 0);
    chk("R11 irq cleared", irq_o, 0);

    cyc(5);
    chk("R5 missing pulses", ovf_q.size(), 0);
    chk("R6 missing resets", rlen_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule